// File: doc/BRIEF.md
# Periodic Online FIFO Test Scheduler

This block wraps the storage of a router input-channel FIFO and takes it offline for a short check at regular intervals, so that faults that develop in the field are caught before they pile up. A free-running interval counter decides when a burst starts. It does not look at how full the FIFO is at that moment. The first burst waits for its own start delay after reset. Each later burst waits for the interval that follows the previous burst.

When a burst begins, the block enters test mode. In that mode the memory's address and write data are handed to an external test engine, and the full indication toward the upstream router is forced high. The engine reads and writes one location only: the one the read pointer points at when the timer fires. Bursts land at different pointer positions over time, so repeated bursts reach different locations. A flit popped in the cycle the timer fires is not lost. It is parked in a holding register and presented one cycle later than usual. The engine ends the burst with a done pulse. If that pulse carries a fault, the failing location is latched in a sticky status output.

Top module: `fifo_test_sched`

## Requirements
- R1: After reset, test_mode, up_full, out_vld and stat_vld are all 0 and the FIFO is empty.
- R2: In normal mode the block behaves as a first-in first-out queue. A pop accepted on a clock edge puts the oldest word on dout with out_vld high for the cycle after that edge. A push while up_full is high is ignored. A pop while empty gives out_vld low. up_full is high when 2^AW words are stored.
- R3: Counting the cycle that ends on the first clock edge after reset release as cycle 0, test_mode rises on the edge that ends cycle start_dly. This happens whether the FIFO is empty, partly filled or full.
- R4: test_mode stays high until a cycle with tst_done high, and falls on the edge that ends that cycle. The next burst then starts on the edge that ends the period-th normal cycle after that, counting from 0, so period+1 normal cycles lie between bursts.
- R5: While test_mode is high, up_full is high and pushes are ignored. No word offered during the burst is ever popped later.
- R6: While test_mode is high, pops are ignored. After the first test cycle, out_vld stays low until the burst ends.
- R7: tst_addr holds the read pointer value from the cycle the timer fired, and it stays stable for the whole burst. tst_rdata shows the memory word at tst_addr.
- R8: During a burst, tst_we high writes tst_wdata into the location tst_addr on that edge, and the word is visible on tst_rdata afterwards.
- R9: A flit popped in the cycle the timer fires is not lost. It appears on dout with out_vld high one cycle later than a normal pop: in the second cycle after the pop edge, rather than the first.
- R10: A cycle with test_mode, tst_done and tst_fault all high sets stat_vld and loads stat_addr with tst_addr. stat_vld then stays high until a stat_clr cycle. A done without a fault leaves the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_dly | input | CW | Normal cycles before the first burst |
| period | input | CW | Normal cycles between bursts |
| push | input | 1 | Write request from upstream |
| din | input | W | Flit to store |
| up_full | output | 1 | Back-pressure to upstream; forced high in test mode |
| pop | input | 1 | Read request from downstream |
| dout | output | W | Flit read out |
| out_vld | output | 1 | dout holds a new flit this cycle |
| test_mode | output | 1 | Burst in progress |
| tst_addr | output | AW | Location under test |
| tst_rdata | output | W | Memory word at tst_addr |
| tst_we | input | 1 | Test engine write strobe |
| tst_wdata | input | W | Test engine write data |
| tst_done | input | 1 | Test engine finished the burst |
| tst_fault | input | 1 | Fault found, qualified by tst_done |
| stat_clr | input | 1 | Clear the sticky fault status |
| stat_vld | output | 1 | A failing burst was recorded |
| stat_addr | output | AW | Location of the recorded failure |

## Verification
The hardest case to reach from the ports is a pop that falls exactly in the cycle the timer fires. Only in that cycle are the holding register and the delayed output path used. The stimulus gets there by resetting the block with a small start delay and counting edges from reset release. It fills the queue and places a pop in cycle start_dly. It then checks the delayed flit, the target address and the surviving contents. A second sequence confirms the interval reload from an empty queue.

// File: rtl/fifo_test_sched.sv
module fifo_test_sched #(
  parameter int W  = 16,
  parameter int AW = 3,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] start_dly,
  input  logic [CW-1:0] period,
  input  logic          push,
  input  logic [W-1:0]  din,
  output logic          up_full,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          out_vld,
  output logic          test_mode,
  output logic [AW-1:0] tst_addr,
  output logic [W-1:0]  tst_rdata,
  input  logic          tst_we,
  input  logic [W-1:0]  tst_wdata,
  input  logic          tst_done,
  input  logic          tst_fault,
  input  logic          stat_clr,
  output logic          stat_vld,
  output logic [AW-1:0] stat_addr
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp, tgt;
  logic [AW:0]   fill;
  logic [CW-1:0] cnt;
  logic          armed, fire, wr_ok, pop_ok;
  logic [W-1:0]  hold;
  logic          hold_v;
  logic          mem_we;
  logic [AW-1:0] mem_wa;
  logic [W-1:0]  mem_wd;

  assign up_full   = test_mode || (fill == (AW+1)'(DEPTH));
  assign wr_ok     = push && !up_full;
  assign pop_ok    = pop && !test_mode && (fill != '0);
  assign fire      = !test_mode && (cnt >= (armed ? period : start_dly));
  assign tst_addr  = tgt;
  assign tst_rdata = mem[tgt];

  assign mem_we = test_mode ? tst_we    : wr_ok;
  assign mem_wa = test_mode ? tgt       : wp;
  assign mem_wd = test_mode ? tst_wdata : din;

  always_ff @(posedge clk)
    if (mem_we) mem[mem_wa] <= mem_wd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      fill <= '0;
      out_vld <= 1'b0;
      dout <= '0;
      hold <= '0;
      hold_v <= 1'b0;
    end else begin
      if (wr_ok) wp <= wp + AW'(1);
      if (pop_ok) rp <= rp + AW'(1);
      fill <= fill + (AW+1)'(wr_ok) - (AW+1)'(pop_ok);
      hold_v <= fire && pop_ok;
      if (fire) hold <= mem[rp];
      out_vld <= (pop_ok && !fire) || hold_v;
      if (hold_v) dout <= hold;
      else if (pop_ok && !fire) dout <= mem[rp];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      armed <= 1'b0;
      test_mode <= 1'b0;
      tgt <= '0;
    end else if (fire) begin
      test_mode <= 1'b1;
      tgt <= rp;
      cnt <= '0;
      armed <= 1'b1;
    end else if (test_mode) begin
      if (tst_done) test_mode <= 1'b0;
      cnt <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_vld <= 1'b0;
      stat_addr <= '0;
    end else if (test_mode && tst_done && tst_fault) begin
      stat_vld <= 1'b1;
      stat_addr <= tgt;
    end else if (stat_clr) begin
      stat_vld <= 1'b0;
    end
  end
endmodule

// File: rtl/fifo_test_sched_chk.sv
module fifo_test_sched_chk #(
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          test_mode,
  input logic          up_full,
  input logic          tst_done,
  input logic          tst_fault,
  input logic [AW-1:0] tst_addr,
  input logic          out_vld,
  input logic          stat_vld
);
  AST_FULL_IN_TEST: assert property (@(posedge clk) disable iff (!rst_n) test_mode |-> up_full); // R5
  AST_TEST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) test_mode && !tst_done |=> test_mode); // R4
  AST_TEST_ENDS: assert property (@(posedge clk) disable iff (!rst_n) test_mode && tst_done |=> !test_mode); // R4
  AST_TARGET_STABLE: assert property (@(posedge clk) disable iff (!rst_n) test_mode && $past(test_mode) |-> $stable(tst_addr)); // R7
  AST_NO_POP_IN_TEST: assert property (@(posedge clk) disable iff (!rst_n) $past(test_mode) && $past(test_mode, 2) |-> !out_vld); // R6
  AST_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n) $rose(stat_vld) |-> $past(test_mode && tst_done && tst_fault)); // R10
endmodule

bind fifo_test_sched fifo_test_sched_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .up_full(up_full),
  .tst_done(tst_done), .tst_fault(tst_fault), .tst_addr(tst_addr),
  .out_vld(out_vld), .stat_vld(stat_vld)
);

// File: tb/sim_fifo_test_sched.sv
module sim_fifo_test_sched;
  localparam int W = 16, AW = 3, CW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CW-1:0] start_dly = '1, period = '1;
  logic push = 0, pop = 0, tst_we = 0, tst_done = 0, tst_fault = 0, stat_clr = 0;
  logic [W-1:0] din = '0, tst_wdata = '0;
  logic up_full, out_vld, test_mode, stat_vld;
  logic [W-1:0] dout, tst_rdata;
  logic [AW-1:0] tst_addr, stat_addr;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  fifo_test_sched #(.W(W), .AW(AW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_dly(start_dly), .period(period),
    .push(push), .din(din), .up_full(up_full), .pop(pop), .dout(dout),
    .out_vld(out_vld), .test_mode(test_mode), .tst_addr(tst_addr),
    .tst_rdata(tst_rdata), .tst_we(tst_we), .tst_wdata(tst_wdata),
    .tst_done(tst_done), .tst_fault(tst_fault), .stat_clr(stat_clr),
    .stat_vld(stat_vld), .stat_addr(stat_addr)
  );

  // {push, pop, din, exp_vld, exp_dout, exp_full}
  localparam logic [35:0] VEC [0:19] = '{
    {1'b1,1'b0,16'hA000,1'b0,16'h0000,1'b0},
    {1'b1,1'b0,16'hA001,1'b0,16'h0000,1'b0},
    {1'b1,1'b0,16'hA002,1'b0,16'h0000,1'b0},
    {1'b1,1'b0,16'hA003,1'b0,16'h0000,1'b0},
    {1'b1,1'b0,16'hA004,1'b0,16'h0000,1'b0},
    {1'b1,1'b0,16'hA005,1'b0,16'h0000,1'b0},
    {1'b1,1'b0,16'hA006,1'b0,16'h0000,1'b0},
    {1'b1,1'b0,16'hA007,1'b0,16'h0000,1'b1},
    {1'b1,1'b0,16'hA0FF,1'b0,16'h0000,1'b1},
    {1'b1,1'b1,16'hA0EE,1'b1,16'hA000,1'b0},
    {1'b1,1'b1,16'hB001,1'b1,16'hA001,1'b0},
    {1'b0,1'b1,16'h0000,1'b1,16'hA002,1'b0},
    {1'b0,1'b1,16'h0000,1'b1,16'hA003,1'b0},
    {1'b0,1'b1,16'h0000,1'b1,16'hA004,1'b0},
    {1'b0,1'b1,16'h0000,1'b1,16'hA005,1'b0},
    {1'b0,1'b1,16'h0000,1'b1,16'hA006,1'b0},
    {1'b0,1'b1,16'h0000,1'b1,16'hA007,1'b0},
    {1'b0,1'b1,16'h0000,1'b1,16'hB001,1'b0},
    {1'b0,1'b1,16'h0000,1'b0,16'h0000,1'b0},
    {1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [CW-1:0] sd, input logic [CW-1:0] pd);
    rst_n = 0; start_dly = sd; period = pd;
    push = 0; pop = 0; tst_we = 0; tst_done = 0; tst_fault = 0; stat_clr = 0;
    tick(); tick();
    rst_n = 1;
  endtask

  initial begin
    tick();
    do_reset('1, '1);
    chk("R1 test_mode", 32'(test_mode), 0);
    chk("R1 up_full", 32'(up_full), 0);
    chk("R1 out_vld", 32'(out_vld), 0);
    chk("R1 stat_vld", 32'(stat_vld), 0);

    for (int i = 0; i < 20; i++) begin
      push = VEC[i][35]; pop = VEC[i][34]; din = VEC[i][33:18];
      tick();
      chk($sformatf("R2 vec%0d out_vld", i), 32'(out_vld), 32'(VEC[i][17]));
      if (VEC[i][17]) chk($sformatf("R2 vec%0d dout", i), 32'(dout), 32'(VEC[i][16:1]));
      chk($sformatf("R2 vec%0d up_full", i), 32'(up_full), 32'(VEC[i][0]));
    end
    push = 0; pop = 0;

    // R3 / R4: timer bursts on an empty FIFO
    do_reset(16'd5, 16'd3);
    repeat (5) tick();
    chk("R3 no burst before start_dly", 32'(test_mode), 0);
    tick();
    chk("R3 burst starts on empty fifo", 32'(test_mode), 1);
    chk("R5 up_full forced", 32'(up_full), 1);
    chk("R7 target is read pointer", 32'(tst_addr), 0);
    tst_done = 1; tick(); tst_done = 0;
    chk("R4 burst ends on done", 32'(test_mode), 0);
    chk("R10 clean done keeps status", 32'(stat_vld), 0);
    repeat (3) tick();
    chk("R4 no burst before period", 32'(test_mode), 0);
    tick();
    chk("R4 second burst after period", 32'(test_mode), 1);
    tst_done = 1; tick(); tst_done = 0;

    // R9 / R7 / R8 / R5 / R6 / R10: pop in the firing cycle
    do_reset(16'd5, '1);
    push = 1;
    din = 16'hC000; tick();
    din = 16'hC001; tick();
    din = 16'hC002; tick();
    push = 0; pop = 1; tick();
    chk("R2 normal pop vld", 32'(out_vld), 1);
    chk("R2 normal pop data", 32'(dout), 32'h0000C000);
    pop = 0; tick();
    pop = 1; tick();
    chk("R3 burst with partly filled fifo", 32'(test_mode), 1);
    chk("R9 flit not shown on normal cycle", 32'(out_vld), 0);
    chk("R7 target addr", 32'(tst_addr), 1);
    chk("R7 target data", 32'(tst_rdata), 32'h0000C001);
    push = 1; din = 16'hD000; tick();
    chk("R9 delayed flit vld", 32'(out_vld), 1);
    chk("R9 delayed flit data", 32'(dout), 32'h0000C001);
    push = 0; tick();
    chk("R6 pop ignored in test", 32'(out_vld), 0);
    pop = 0; tst_we = 1; tst_wdata = 16'h3FFE; tick(); tst_we = 0;
    chk("R8 test write", 32'(tst_rdata), 32'h00003FFE);
    chk("R7 target stable", 32'(tst_addr), 1);
    tst_done = 1; tst_fault = 1; tick(); tst_done = 0; tst_fault = 0;
    chk("R4 burst ended", 32'(test_mode), 0);
    chk("R10 status set", 32'(stat_vld), 1);
    chk("R10 status addr", 32'(stat_addr), 1);
    chk("R5 up_full released", 32'(up_full), 0);
    pop = 1; tick();
    chk("R5 remaining entry vld", 32'(out_vld), 1);
    chk("R5 remaining entry data", 32'(dout), 32'h0000C002);
    tick();
    chk("R5 push during test not stored", 32'(out_vld), 0);
    pop = 0; repeat (3) tick();
    chk("R10 status sticky", 32'(stat_vld), 1);
    stat_clr = 1; tick(); stat_clr = 0;
    chk("R10 status cleared", 32'(stat_vld), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule